// File: doc/BRIEF.md
# TDM Daisy-Chain Capture Transmitter

This block is the record-side serial port of one converter device that sits in a two-device time-division-multiplexed chain feeding a DSP. Each frame it takes four 32-bit channel words from its own converters on a parallel bus. It also listens to the serial output of the device upstream of it on a chain input. It then shifts out one combined frame toward the DSP. The first four slots carry the upstream device's channels and the next four carry its own.

The block runs on a fast system clock. It samples the bit clock, the frame clock and the chain input through a short synchronizer, and it acts on the edges it detects. A configuration bit selects a 256-bit frame (eight slots) or a 512-bit frame (sixteen slots, with the last eight slots always zero). Two more bits invert the sense of the bit clock and the frame clock. The device at the head of the chain has its chain input tied low, so it sends zeros in the upstream slots.

Top module: `tdm_chain_tx`

## Requirements
- R1: After reset, and until the first frame start, `sdout_o` is 0.
- R2: Each slot is 32 bits, sent MSB first. Slots 0..3 carry upstream words 0..3. Slots 4..7 carry own words 0..3. Own word k is `own_data_i[127-32k -: 32]`.
- R3: The block takes the upstream words from chain-input bits 128..255 of a frame (chain slots 4..7) and sends them in slots 0..3 of the next frame. Chain bits outside that range have no effect on the output.
- R4: On a valid pulse, the block takes the own words present at that pulse, and it sends them from the frame after the next frame start. A valid pulse during a frame does not alter that frame's output. When a frame has two pulses, the later one wins.
- R5: When no valid pulse arrives between two frame starts, the block sends the previous own words again.
- R6: With `long_frame_i`=1 a frame is 512 bits, and slots 8..15 are 0.
- R7: With `long_frame_i`=0 a new frame begins after bit 255 even when no frame-clock edge arrives.
- R8: A chain input held at 0 gives zero words in slots 0..3 of the next frame.
- R9: The normalized bit clock is `bclk_i` XOR `bclk_inv_i`, and the normalized frame clock is `fs_i` XOR `fs_inv_i`. Data is launched on the falling edge of the normalized bit clock. The chain input and the frame clock are sampled on the rising edge.
- R10: A frame starts at a rising bit-clock edge where the normalized frame clock is 1 and was 0 at the previous rising edge. Bit 0 of the frame is driven on the falling edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| fs_i | input | 1 | Frame clock |
| bclk_inv_i | input | 1 | Invert bit-clock sense |
| fs_inv_i | input | 1 | Invert frame-clock sense |
| long_frame_i | input | 1 | 1: 512-bit frame, 0: 256-bit frame |
| chain_i | input | 1 | Serial stream from the upstream device |
| own_data_i | input | 128 | Four own channel words, word 0 in the top bits |
| own_vld_i | input | 1 | Pulse: own_data_i holds new words |
| sdout_o | output | 1 | Serial TDM output toward the DSP |

## Verification
The input synchronizer has two stages and the output flop adds one more, so a new output bit settles about three system clocks after a falling bit-clock edge. The bench holds each bit-clock phase for eight system clocks. It samples the output in the last system clock before the rising edge, which is the point where a downstream receiver would latch it. Own words latched by a mid-frame valid pulse are expected in the following frame. Upstream words are expected one frame after they were received. The bench's model pushes each frame's expected slots before the frame is clocked out, so the monitor compares every 32 sampled bits against the word that is due in that slot.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

  // Source chosen for the slot currently being shifted out
  typedef enum logic [1:0] {
    SRC_UPSTREAM = 2'd0,
    SRC_LOCAL    = 2'd1,
    SRC_BLANK    = 2'd2
  } slot_src_e;

  // Frame is split into blocks of CHAIN_SLOTS slots: block 0 upstream,
  // block 1 local words, every later block empty.
  function automatic slot_src_e block_source(input int unsigned blk);
    if (blk == 0)      return SRC_UPSTREAM;
    else if (blk == 1) return SRC_LOCAL;
    else               return SRC_BLANK;
  endfunction

endpackage

// File: rtl/tdm_edge_detect.sv
module tdm_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic chain_i,
  input  logic bclk_inv_i,
  input  logic fs_inv_i,
  output logic rise_o,
  output logic fall_o,
  output logic fs_start_o,
  output logic chain_bit_o
);
  // bit order in the synchronizer word
  localparam int unsigned B_IDX = 2;
  localparam int unsigned F_IDX = 1;
  localparam int unsigned C_IDX = 0;

  logic [2:0] raw;
  logic [2:0] stage [SYNC_STAGES];
  logic       b_prev;
  logic       fs_prev;

  assign raw = {bclk_i ^ bclk_inv_i, fs_i ^ fs_inv_i, chain_i};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else if (g == 0) stage[g] <= raw;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  logic [2:0] synced;
  assign synced = stage[SYNC_STAGES-1];

  assign rise_o      = synced[B_IDX] & ~b_prev;
  assign fall_o      = ~synced[B_IDX] & b_prev;
  assign fs_start_o  = rise_o & synced[F_IDX] & ~fs_prev;
  assign chain_bit_o = synced[C_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      b_prev  <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      b_prev <= synced[B_IDX];
      if (rise_o) fs_prev <= synced[F_IDX];
    end
  end
endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int unsigned HALF_BITS = 128
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rise_i,
  input  logic                             fs_start_i,
  input  logic                             long_frame_i,
  output logic [$clog2(4*HALF_BITS)-1:0]   cnt_o,
  output logic                             boundary_o,
  output logic                             synced_o
);
  localparam int unsigned CNT_W = $clog2(4 * HALF_BITS);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(2 * HALF_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(4 * HALF_BITS - 1);

  logic [CNT_W-1:0] last_idx;
  logic             wrap;

  assign last_idx   = long_frame_i ? LAST_LONG : LAST_SHORT;
  assign wrap       = synced_o & (cnt_o == last_idx);
  assign boundary_o = rise_i & (fs_start_i | wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      synced_o <= 1'b0;
    end else if (boundary_o) begin
      cnt_o    <= '0;
      synced_o <= 1'b1;
    end else if (rise_i && synced_o) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tdm_chain_capture.sv
module tdm_chain_capture #(
  parameter int unsigned HALF_BITS = 128
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rise_i,
  input  logic                           synced_i,
  input  logic                           boundary_i,
  input  logic                           chain_bit_i,
  input  logic [$clog2(4*HALF_BITS)-1:0] cnt_i,
  output logic [HALF_BITS-1:0]           up_words_o
);
  localparam int unsigned CNT_W  = $clog2(4 * HALF_BITS);
  localparam int unsigned HALF_W = $clog2(HALF_BITS);

  logic [HALF_BITS-1:0] shreg;
  logic [HALF_BITS-1:0] shreg_nxt;
  logic                 take;

  // second block of the upstream frame holds the upstream device's own words
  assign take = rise_i & synced_i & (cnt_i[CNT_W-1:HALF_W] == (CNT_W - HALF_W)'(1));
  assign shreg_nxt = take ? {shreg[HALF_BITS-2:0], chain_bit_i} : shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      up_words_o <= '0;
    end else if (boundary_i) begin
      up_words_o <= shreg_nxt;
      shreg      <= '0;
    end else begin
      shreg <= shreg_nxt;
    end
  end
endmodule

// File: rtl/tdm_own_latch.sv
module tdm_own_latch #(
  parameter int unsigned HALF_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HALF_BITS-1:0] own_data_i,
  input  logic                 own_vld_i,
  input  logic                 boundary_i,
  output logic [HALF_BITS-1:0] own_tx_o
);
  logic [HALF_BITS-1:0] pend;
  logic                 fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      fresh    <= 1'b0;
      own_tx_o <= '0;
    end else begin
      if (own_vld_i) pend <= own_data_i;
      if (boundary_i) begin
        if (fresh) own_tx_o <= pend;
        fresh <= own_vld_i;
      end else if (own_vld_i) begin
        fresh <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx #(
  parameter int unsigned SLOT_BITS   = 32,
  parameter int unsigned CHAIN_SLOTS = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bclk_i,
  input  logic                             fs_i,
  input  logic                             bclk_inv_i,
  input  logic                             fs_inv_i,
  input  logic                             long_frame_i,
  input  logic                             chain_i,
  input  logic [SLOT_BITS*CHAIN_SLOTS-1:0] own_data_i,
  input  logic                             own_vld_i,
  output logic                             sdout_o
);
  import tdm_chain_pkg::*;

  // HALF_BITS must be a power of two
  localparam int unsigned HALF_BITS = SLOT_BITS * CHAIN_SLOTS;
  localparam int unsigned HALF_W    = $clog2(HALF_BITS);
  localparam int unsigned CNT_W     = $clog2(4 * HALF_BITS);

  logic                 edg_rise, edg_fall, edg_fs_start, chain_bit;
  logic [CNT_W-1:0]     cnt_q;
  logic                 boundary, synced;
  logic [HALF_BITS-1:0] up_words, own_tx;
  logic [HALF_W-1:0]    bit_idx;
  slot_src_e            src;
  logic                 next_bit;

  tdm_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .bclk_i     (bclk_i),
    .fs_i       (fs_i),
    .chain_i    (chain_i),
    .bclk_inv_i (bclk_inv_i),
    .fs_inv_i   (fs_inv_i),
    .rise_o     (edg_rise),
    .fall_o     (edg_fall),
    .fs_start_o (edg_fs_start),
    .chain_bit_o(chain_bit)
  );

  tdm_slot_counter #(.HALF_BITS(HALF_BITS)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (edg_rise),
    .fs_start_i  (edg_fs_start),
    .long_frame_i(long_frame_i),
    .cnt_o       (cnt_q),
    .boundary_o  (boundary),
    .synced_o    (synced)
  );

  tdm_chain_capture #(.HALF_BITS(HALF_BITS)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (edg_rise),
    .synced_i   (synced),
    .boundary_i (boundary),
    .chain_bit_i(chain_bit),
    .cnt_i      (cnt_q),
    .up_words_o (up_words)
  );

  tdm_own_latch #(.HALF_BITS(HALF_BITS)) u_own (
    .clk       (clk),
    .rst       (rst),
    .own_data_i(own_data_i),
    .own_vld_i (own_vld_i),
    .boundary_i(boundary),
    .own_tx_o  (own_tx)
  );

  // MSB of word 0 sits in the top bit of each block
  assign bit_idx = ~cnt_q[HALF_W-1:0];
  assign src     = block_source(int'(cnt_q[CNT_W-1:HALF_W]));

  always_comb begin
    case (src)
      SRC_UPSTREAM: next_bit = up_words[bit_idx];
      SRC_LOCAL:    next_bit = own_tx[bit_idx];
      default:      next_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sdout_o <= 1'b0;
    else if (edg_fall) sdout_o <= synced & next_bit;
  end
endmodule

// File: rtl/tdm_chain_tx_chk.sv
module tdm_chain_tx_chk #(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned HALF_BITS = 128
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rise,
  input logic                 fall,
  input logic                 boundary,
  input logic                 synced,
  input logic                 long_frame,
  input logic [CNT_W-1:0]     cnt,
  input logic [HALF_BITS-1:0] up_words,
  input logic [HALF_BITS-1:0] own_tx,
  input logic                 sdout
);
  assert_quiet_before_frame_R1: assert property (@(posedge clk) disable iff (rst)
    !synced |-> !sdout);

  assert_up_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(up_words));

  assert_own_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(own_tx));

  assert_empty_tail_R6: assert property (@(posedge clk) disable iff (rst)
    (fall && cnt[CNT_W-1]) |=> !sdout);

  // configuration is changed only while reset is held
  assert_short_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (synced && !long_frame) |-> !cnt[CNT_W-1]);

  assert_launch_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sdout));

  assert_start_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
    boundary |-> rise);
endmodule

bind tdm_chain_tx tdm_chain_tx_chk #(.CNT_W(CNT_W), .HALF_BITS(HALF_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rise      (edg_rise),
  .fall      (edg_fall),
  .boundary  (boundary),
  .synced    (synced),
  .long_frame(long_frame_i),
  .cnt       (cnt_q),
  .up_words  (up_words),
  .own_tx    (own_tx),
  .sdout     (sdout_o)
);

// File: tb/tdm_chain_tx_tb.sv
module tdm_chain_tx_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk_i = 1'b1, fs_i = 1'b0, bclk_inv_i = 1'b0, fs_inv_i = 1'b0;
  logic         long_frame_i = 1'b0, chain_i = 1'b0, own_vld_i = 1'b0;
  logic [127:0] own_data_i = '0;
  logic         sdout_o;
  logic         strobe = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tdm_chain_tx u_dut (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fs_i(fs_i),
    .bclk_inv_i(bclk_inv_i), .fs_inv_i(fs_inv_i), .long_frame_i(long_frame_i),
    .chain_i(chain_i), .own_data_i(own_data_i), .own_vld_i(own_vld_i),
    .sdout_o(sdout_o)
  );

  // scoreboard queues
  logic [31:0] exp_w[$];
  string       exp_tag[$];

  // reference model state
  logic [31:0] up_prev [4];
  logic [31:0] own_tx  [4];
  logic [127:0] pend_m;
  logic        fresh_m;
  logic [31:0] cur_chain [16];

  // monitor: assemble 32 sampled bits and compare with the due word
  logic [31:0] obs = '0;
  int          nbits = 0;
  always @(negedge clk) begin
    if (strobe) begin
      obs = {obs[30:0], sdout_o};
      nbits++;
      if (nbits == 32) begin
        nbits = 0;
        checks++;
        if (exp_w.size() == 0) begin
          failures++;
          $display("FAIL unexpected word: actual=%h expected=none", obs);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_w.pop_front();
          t = exp_tag.pop_front();
          if (obs !== e) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", t, obs, e);
          end
        end
      end
    end
  end

  task automatic push_exp(input logic [31:0] w, input string t);
    exp_w.push_back(w);
    exp_tag.push_back(t);
  endtask

  // one bit-clock period: low phase then high phase (normalized)
  task automatic bit_cycle(input logic fs_n, input logic ch);
    @(posedge clk);
    bclk_i  <= bclk_inv_i;
    fs_i    <= fs_n ^ fs_inv_i;
    chain_i <= ch;
    repeat (7) @(posedge clk);
    strobe <= 1'b1;
    @(posedge clk);
    strobe <= 1'b0;
    bclk_i <= ~bclk_inv_i;
    repeat (7) @(posedge clk);
  endtask

  task automatic pulse_own(input logic [127:0] d);
    @(posedge clk);
    own_data_i <= d;
    own_vld_i  <= 1'b1;
    @(posedge clk);
    own_vld_i  <= 1'b0;
    own_data_i <= ~d;  // later bus changes must not leak in
    pend_m  = d;
    fresh_m = 1'b1;
  endtask

  task automatic model_boundary(input logic cap_chain);
    for (int k = 0; k < 4; k++) up_prev[k] = cap_chain ? cur_chain[4+k] : 32'h0;
    if (fresh_m) for (int k = 0; k < 4; k++) own_tx[k] = pend_m[127-32*k -: 32];
    fresh_m = 1'b0;
  endtask

  task automatic do_reset(input logic binv, input logic finv, input logic lng);
    @(posedge clk);
    rst <= 1'b1;
    bclk_inv_i <= binv; fs_inv_i <= finv; long_frame_i <= lng;
    bclk_i <= ~binv; fs_i <= finv; own_vld_i <= 1'b0;
    repeat (6) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    checks++;
    if (sdout_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual=%b expected=0", sdout_o);
    end
    for (int k = 0; k < 4; k++) begin up_prev[k] = '0; own_tx[k] = '0; end
    pend_m = '0; fresh_m = 1'b0;
  endtask

  // 32 idle bit periods ending in the first frame start; output must stay 0 (R1)
  task automatic prime(input logic do_pulse, input logic [127:0] d);
    push_exp(32'h0, "R1 idle");
    for (int m = 0; m < 32; m++) begin
      if (do_pulse && m == 5) pulse_own(d);
      bit_cycle(m == 31, 1'($urandom));
    end
    model_boundary(1'b0);
  endtask

  task automatic run_frame(input int nslots, input logic fs_end, input int npulse,
                           input logic [127:0] a, input logic [127:0] b, input string note);
    for (int s = 0; s < nslots; s++) begin
      if (s < 4)      push_exp(up_prev[s],  {"R2 R3 R8 upstream ", note});
      else if (s < 8) push_exp(own_tx[s-4], {"R2 R4 R5 own ", note});
      else            push_exp(32'h0,       {"R6 empty ", note});
    end
    for (int m = 0; m < nslots * 32; m++) begin
      if (npulse >= 1 && m == 40) pulse_own(a);
      if (npulse >= 2 && m == 80) pulse_own(b);
      bit_cycle(fs_end && (m == nslots * 32 - 1), cur_chain[m / 32][31 - (m % 32)]);
    end
    model_boundary(1'b1);
  endtask

  task automatic fill_chain(input logic zero);
    for (int s = 0; s < 16; s++) cur_chain[s] = zero ? 32'h0 : $urandom;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] wa, wb, wc;
    // 256-bit frames, normal polarity (R9, R10)
    do_reset(1'b0, 1'b0, 1'b0);
    wa = rnd128();
    prime(1'b1, wa);
    fill_chain(1'b0);
    run_frame(8, 1'b1, 0, '0, '0, "f1");           // R4: words latched before first start
    wb = rnd128();
    fill_chain(1'b0);
    run_frame(8, 1'b1, 1, wb, '0, "f2");           // R5: no pulse in f1, resend
    wa = rnd128(); wc = rnd128();
    fill_chain(1'b0);
    run_frame(8, 1'b1, 2, wa, wc, "f3");           // R4: two pulses, later wins
    fill_chain(1'b1);
    run_frame(8, 1'b0, 0, '0, '0, "f4 R7 no edge"); // R7: wrap without frame-clock edge
    fill_chain(1'b0);
    run_frame(8, 1'b1, 0, '0, '0, "f5 R8 after zero chain");
    fill_chain(1'b0);
    run_frame(8, 1'b1, 0, '0, '0, "f6");

    // 512-bit frames, both clocks inverted (R6, R9)
    do_reset(1'b1, 1'b1, 1'b1);
    wa = rnd128();
    prime(1'b1, wa);
    fill_chain(1'b0);
    run_frame(16, 1'b1, 1, rnd128(), '0, "L1 R9 inverted");
    fill_chain(1'b0);
    run_frame(16, 1'b1, 0, '0, '0, "L2 R6");
    fill_chain(1'b0);
    run_frame(16, 1'b0, 0, '0, '0, "L3 R6 wrap");

    repeat (20) @(posedge clk);
    checks++;
    if (exp_w.size() != 0 || nbits != 0) begin
      failures++;
      $display("FAIL R2 scoreboard drain: actual=%0d left expected=0", exp_w.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule